// File: doc/BRIEF.md
# Synchronized Multi-Channel Timer Group

Three 16-bit up-counters share one small synchronous register port. A run register holds one run bit per channel. A group register marks the channels that work together. When at least two channels are marked, they form a group with two shared behaviours:

- A write to the counter of any group member loads the same value into every member's counter.
- A member that clears on its own compare match also clears every other member that has picked group clearing as its clear source.

Each channel also drives one compare output pin. The pin has a programmable starting level and toggles on each compare match.

Software programs each channel through its registers: counter, compare value, and a control word. The control word holds a clear-source field and an output-action field. Reads are combinational from the address. Writes take effect at the next rising clock edge.

Top module: `tmr_sync_group`

## Requirements
- R1: After reset, every register reads 0 and every `tout` and `toe` bit is 0. Register addresses are:
  - run = 0x0
  - group = 0x1
  - counter n = 0x4+n
  - compare n = 0x8+n
  - control n = 0xC+n
- R2: Run register bit n (bits 2..0) lets counter n count. A running counter adds 1 on each clock edge and wraps from 0xFFFF to 0x0000. A stopped counter holds its value.
- R3: The group register keeps only bits 2..0, one per channel. Bits 7..3 always read 0, and writes to them are ignored.
- R4: When two or more group bits are set, a write to the counter of any marked channel loads the written value into every marked counter, including stopped ones. Unmarked counters are not changed.
- R5: When only one group bit is set, that channel acts on its own: a write to its counter changes no other counter.
- R6: Control bits 2..0 select the clear source:
  - 000 = never clear.
  - 001 = clear on own match.
  - 011 = group clear.
  - Any other code = never clear.
  A match means the channel is running and its counter equals its compare value. With source 001, the edge after a match sets the counter to 0 instead of incrementing it.
- R7: A marked channel with clear source 011 is set to 0 on the same edge as another marked channel's own-match clear. A channel with source 011 whose group bit is not set (or that is not in a group of at least two) keeps counting.
- R8: A counter write takes priority over both clearing and counting on the same edge.
- R9: Control bits 5..4 select the output action:
  - 01 = start low, toggle on match.
  - 10 = start high, toggle on match.
  - 00 or 11 = output disabled (`toe` low).
  Writing a channel's control word while that channel is stopped sets its pin to the starting level. Writing it while the channel runs leaves the pin unchanged.
- R10: On each match in action 01 or 10, the pin toggles on the next edge. Clearing a run bit freezes the pin at its present level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| tout | output | 3 | Compare output pin level, one per channel |
| toe | output | 3 | Compare output enable, one per channel |

## Verification
Two functions can fall on the same edge: a group preset written by software and a compare-match clear. The bench runs two grouped counters up until one of them sits on its compare value with own-match clearing selected. In exactly that cycle it writes the other member's counter. On that edge the preset should win over the clear and the increment, so both counters must read the written value and not zero. A companion case drives a member clear into a peer with group clearing selected, while an ungrouped channel with the same clear code keeps counting.

// File: rtl/tmr_sync_group.sv
module tmr_sync_group #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [2:0]    tout,
  output logic [2:0]    toe
);
  localparam int NCH = 3;
  localparam logic [3:0] A_RUN = 4'h0;
  localparam logic [3:0] A_GRP = 4'h1;
  localparam logic [1:0] PG_CNT = 2'b01;
  localparam logic [1:0] PG_CMP = 2'b10;
  localparam logic [1:0] PG_CTL = 2'b11;
  localparam logic [2:0] CS_OWN = 3'b001;
  localparam logic [2:0] CS_GRP = 3'b011;

  logic [NCH-1:0]         run_q, sync_q, pin_q;
  logic [NCH-1:0][CW-1:0] cnt_q, cmp_q;
  logic [NCH-1:0][2:0]    clr_q;
  logic [NCH-1:0][1:0]    act_q;

  logic           grp;
  logic [NCH-1:0] insync, match, own_clr, load, clr, ctl_wr;
  logic           peer_clr, cnt_sel, preset_grp;

  assign grp      = (sync_q[0] & sync_q[1]) | (sync_q[0] & sync_q[2]) | (sync_q[1] & sync_q[2]);
  assign insync   = sync_q & {NCH{grp}};
  assign peer_clr = |(insync & own_clr);
  assign cnt_sel  = wr_en && addr[3:2] == PG_CNT && addr[1:0] != 2'd3;

  always_comb begin
    preset_grp = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (cnt_sel && addr[1:0] == 2'(i) && insync[i]) preset_grp = 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign match[i]   = run_q[i] && cnt_q[i] == cmp_q[i];
    assign own_clr[i] = match[i] && clr_q[i] == CS_OWN;
    assign clr[i]     = own_clr[i] || (insync[i] && clr_q[i] == CS_GRP && peer_clr);
    assign load[i]    = cnt_sel && (addr[1:0] == 2'(i) || (preset_grp && insync[i]));
    assign ctl_wr[i]  = wr_en && addr == {PG_CTL, 2'(i)};
    assign toe[i]     = act_q[i] == 2'b01 || act_q[i] == 2'b10;
    assign tout[i]    = pin_q[i];

    always_ff @(posedge clk) begin
      if (rst)              cnt_q[i] <= '0;
      else if (load[i])     cnt_q[i] <= wdata;
      else if (clr[i])      cnt_q[i] <= '0;
      else if (run_q[i])    cnt_q[i] <= cnt_q[i] + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[i] <= '0;
        clr_q[i] <= '0;
        act_q[i] <= '0;
        pin_q[i] <= 1'b0;
      end else begin
        if (wr_en && addr == {PG_CMP, 2'(i)}) cmp_q[i] <= wdata;
        if (ctl_wr[i]) begin
          clr_q[i] <= wdata[2:0];
          act_q[i] <= wdata[5:4];
        end
        if (ctl_wr[i] && !run_q[i]) pin_q[i] <= wdata[5:4] == 2'b10;
        else if (match[i] && toe[i]) pin_q[i] <= ~pin_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      sync_q <= '0;
    end else if (wr_en) begin
      if (addr == A_RUN) run_q  <= wdata[2:0];
      if (addr == A_GRP) sync_q <= wdata[2:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_RUN) rdata = CW'(run_q);
    if (addr == A_GRP) rdata = CW'(sync_q);
    for (int i = 0; i < NCH; i++) begin
      if (addr == {PG_CNT, 2'(i)}) rdata = cnt_q[i];
      if (addr == {PG_CMP, 2'(i)}) rdata = cmp_q[i];
      if (addr == {PG_CTL, 2'(i)}) rdata = CW'({act_q[i], 1'b0, clr_q[i]});
    end
  end
endmodule

// File: rtl/tmr_sync_group_chk.sv
module tmr_sync_group_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic [15:0] wdata,
  input logic        run0,
  input logic        sync0,
  input logic [2:0]  clr0,
  input logic [15:0] cnt0,
  input logic [15:0] cmp0,
  input logic        tout0
);
  a_r1_reset_clean: assert property (@(posedge clk) rst |=> (cnt0 == 16'd0 && !tout0));

  a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
    (run0 && !wr_en && clr0 == 3'b000) |=> cnt0 == $past(cnt0) + 16'd1);

  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run0 && !wr_en && !sync0) |=> $stable(cnt0));

  a_r6_own_clear: assert property (@(posedge clk) disable iff (rst)
    (run0 && cnt0 == cmp0 && clr0 == 3'b001 && !wr_en) |=> cnt0 == 16'd0);

  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'h4) |=> cnt0 == $past(wdata));

  a_r9_init_level: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'hC && !run0 && wdata[5:4] == 2'b10) |=> tout0);

  a_r10_pin_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run0 && !wr_en) |=> $stable(tout0));
endmodule

bind tmr_sync_group tmr_sync_group_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .run0(run_q[0]), .sync0(sync_q[0]), .clr0(clr_q[0]),
  .cnt0(cnt_q[0]), .cmp0(cmp_q[0]), .tout0(tout[0])
);

// File: tb/sim_tmr_sync_group.sv
module sim_tmr_sync_group;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic [2:0]  tout, toe;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  tmr_sync_group u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                     .rdata(rdata), .tout(tout), .toe(toe));

  always #5 clk = ~clk;

  // {addr, write value, expected readback}
  localparam logic [35:0] VEC [6] = '{
    {4'h1, 16'h00FF, 16'h0007},   // R3 reserved bits dropped
    {4'h0, 16'hFFF8, 16'h0000},   // R2 only bits 2..0 kept
    {4'h9, 16'hBEEF, 16'hBEEF},
    {4'hC, 16'hFFFF, 16'h0037},   // R6/R9 fields
    {4'h6, 16'h1234, 16'h1234},
    {4'h1, 16'h0005, 16'h0005}    // R3
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    do_reset();
    // R1
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R1 reg", v, 16'h0);
    end
    chk("R1 pins", {10'b0, toe, tout}, 16'h0);

    foreach (VEC[i]) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rd(VEC[i][35:32], v);
      chk("R3/R2 table", v, VEC[i][15:0]);
    end

    // R2 counting, hold, wrap
    do_reset();
    wr(4'h4, 16'd10);
    wr(4'h0, 16'h1);
    rd(4'h4, v); chk("R2 start", v, 16'd10);
    repeat (5) @(negedge clk);
    rd(4'h4, v); chk("R2 count", v, 16'd15);
    wr(4'h0, 16'h0);
    repeat (3) @(negedge clk);
    rd(4'h4, v); chk("R2 hold", v, 16'd16);
    wr(4'h4, 16'hFFFF);
    wr(4'h0, 16'h1);
    @(negedge clk);
    rd(4'h4, v); chk("R2 wrap", v, 16'h0000);

    // R6 own clear
    do_reset();
    wr(4'hC, 16'h0001);
    wr(4'h8, 16'd5);
    wr(4'h4, 16'd3);
    wr(4'h0, 16'h1);
    repeat (2) @(negedge clk);
    rd(4'h4, v); chk("R6 at match", v, 16'd5);
    @(negedge clk);
    rd(4'h4, v); chk("R6 cleared", v, 16'd0);

    // R4 group preset, R5 lone channel
    do_reset();
    wr(4'h1, 16'h3);
    wr(4'h5, 16'h0100);
    rd(4'h4, v); chk("R4 peer preset", v, 16'h0100);
    rd(4'h5, v); chk("R4 target", v, 16'h0100);
    rd(4'h6, v); chk("R4 unmarked", v, 16'h0000);
    wr(4'h1, 16'h1);
    wr(4'h4, 16'h0055);
    rd(4'h4, v); chk("R5 own", v, 16'h0055);
    rd(4'h5, v); chk("R5 other", v, 16'h0100);

    // R7 group clear
    do_reset();
    wr(4'hC, 16'h0001);
    wr(4'h8, 16'd5);
    wr(4'hD, 16'h0003);
    wr(4'hE, 16'h0003);
    wr(4'h5, 16'h0040);
    wr(4'h4, 16'd3);
    wr(4'h6, 16'h0020);
    wr(4'h1, 16'h3);
    wr(4'h0, 16'h7);
    repeat (2) @(negedge clk);
    rd(4'h5, v); chk("R7 before", v, 16'h0042);
    @(negedge clk);
    rd(4'h4, v); chk("R7 source", v, 16'h0);
    rd(4'h5, v); chk("R7 peer cleared", v, 16'h0);
    rd(4'h6, v); chk("R7 unmarked runs", v, 16'h0023);

    // R8 preset on the clearing edge
    do_reset();
    wr(4'h1, 16'h3);
    wr(4'hC, 16'h0001);
    wr(4'h8, 16'd5);
    wr(4'h4, 16'd3);
    wr(4'h0, 16'h3);
    repeat (2) @(negedge clk);
    rd(4'h4, v); chk("R8 setup", v, 16'd5);
    wr(4'h5, 16'h0077);
    rd(4'h4, v); chk("R8 ch0", v, 16'h0077);
    rd(4'h5, v); chk("R8 ch1", v, 16'h0077);
    @(negedge clk);
    rd(4'h4, v); chk("R8 resumes", v, 16'h0078);

    // R9 / R10 output pin
    do_reset();
    wr(4'hE, 16'h0020);
    chk("R9 init high", {13'b0, toe[2], 1'b0, tout[2]}, 16'h0005);
    wr(4'hA, 16'd2);
    wr(4'h0, 16'h4);
    repeat (2) @(negedge clk);
    chk("R10 before toggle", {15'b0, tout[2]}, 16'h1);
    @(negedge clk);
    chk("R10 toggled", {15'b0, tout[2]}, 16'h0);
    wr(4'h0, 16'h0);
    repeat (3) @(negedge clk);
    chk("R10 frozen", {15'b0, tout[2]}, 16'h0);
    wr(4'hE, 16'h0020);
    chk("R9 stopped high", {15'b0, tout[2]}, 16'h1);
    wr(4'hE, 16'h0010);
    chk("R9 stopped low", {15'b0, tout[2]}, 16'h0);
    wr(4'hE, 16'h0030);
    chk("R9 disabled", {15'b0, toe[2]}, 16'h0);
    wr(4'hE, 16'h0010);
    wr(4'h0, 16'h4);
    wr(4'hE, 16'h0020);
    chk("R9 running no change", {15'b0, tout[2]}, 16'h0);

    finish_run();
  end
endmodule